// File: doc/BRIEF.md
# USB2 Remote Wake-up Assist Timer

This block supervises a suspended high-speed USB2 port while the rest of the system sleeps. Once software arms it, it watches the bus lines for a resume signal (a K state) driven by the attached device. When that K appears it starts a counter that advances on each tick of a slow clock, roughly 30.5 us per tick. When the counter reaches a programmable delay threshold, the block asks for host K to be driven. When it reaches a programmable timeout threshold, it raises a timeout interrupt. Either threshold left at zero falls back to a built-in default. Each default is 3 ticks below its nominal value, which allows for the latency of line-state detection.

Sticky event flags record the sequence as it runs: monitoring started, device K seen, assist released. Three exception flags are kept apart from these: a disconnect, a device K that ended before host K was due, and a port that was not suspended when the block was armed. Per-flag masks and per-line masks gate these flags onto a wake-up interrupt, an exception interrupt and a timeout interrupt. A wake-up request for the power controller combines the first two lines and has its own mask. Software finishes the operation by setting a system-valid bit and a link-ready bit. The block then reports done and stops the counter. Any exception stops it with an error instead.

Top module: `wake_assist_top`

## Requirements
- R1: After reset every register reads zero and hostk_drive, done, error and all interrupt outputs are low.
- R2: Raising assist_en while port_suspended is high starts monitoring and sets event bit 0. Raising it while port_suspended is low goes straight to error and sets event bit 6.
- R3: Control bit 2 picks the K decode. When it is 1, K is line_state == 2'b10. When it is 0, K is fs_vp == 0 with fs_vm == 1. The unselected inputs have no effect.
- R4: The first K while monitoring clears the counter (address 3) to 0 and sets event bit 1. The counter then rises by one per tick.
- R5: hostk_drive rises on the tick where the counter reaches the delay threshold (address 1). A value of 0 means 25 ticks.
- R6: While host K is driven, event bit 8 is set on the tick where the counter reaches the timeout threshold (address 2). A value of 0 means 653 ticks.
- R7: If K ends before host K is driven, the block goes to error and sets event bit 5.
- R8: port_disconnect high while monitoring, counting or driving sends the block to error and sets event bit 4.
- R9: While host K is driven, the block goes to done when control bit 0 (system valid) and bit 1 (link ready) are both set. Event bit 2 is set and the counter stops and holds.
- R10: Writing 1s to address 4 clears those event bits. If a bit is set and cleared in the same tick, the set wins.
- R11: irq_wake is the OR of event bits 0 to 2 not masked in address 5, and is gated by line mask bit 0 (address 6). irq_exc does the same with event bits 4 to 6 and line mask bit 1. irq_tmo is event bit 8 gated by line mask bit 2. wake_req is irq_wake OR irq_exc, gated by line mask bit 3. A mask bit of 1 masks.
- R12: Dropping assist_en returns the block to idle from any state. done, error and hostk_drive go low and the counter holds its value.
- R13: Address 7 reads done in bit 0, error in bit 1 and hostk_drive in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| assist_en | input | 1 | Arms the assist; low returns to idle |
| port_suspended | input | 1 | Port is in suspend |
| port_disconnect | input | 1 | Disconnect detected on the port |
| line_state | input | 2 | Two-bit line state |
| fs_vp | input | 1 | Full-speed single-ended D+ comparator |
| fs_vm | input | 1 | Full-speed single-ended D- comparator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| hostk_drive | output | 1 | Host K should be driven |
| done | output | 1 | Assist finished normally |
| error | output | 1 | Assist stopped on an exception |
| irq_wake | output | 1 | Wake-up interrupt |
| irq_exc | output | 1 | Exception interrupt |
| irq_tmo | output | 1 | Host K timeout interrupt |
| wake_req | output | 1 | Wake-up request to power control |

## Verification
Every state change, counter step and flag update is registered, so each result appears on the first tick after the tick that sampled its cause. The interrupt lines and read data follow the registers combinationally and show up in that same tick. The one exception is a handshake write: the sequencer sees the new control bits one tick after the write, which makes done and the stopped counter appear two ticks after the write. The bench drives inputs at the falling edge and moves a behavioural model at the rising edge. It then compares every output, and the register selected by rd_addr, at the next falling edge, so each expected value is read exactly one register stage after its stimulus.

// File: rtl/wa_pkg.sv
package wa_pkg;

   localparam int ADDR_W = 3;

   // register word addresses
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_DELAY = 3'd1;
   localparam logic [ADDR_W-1:0] A_TMO   = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNT   = 3'd3;
   localparam logic [ADDR_W-1:0] A_EVT   = 3'd4;
   localparam logic [ADDR_W-1:0] A_EVMSK = 3'd5;
   localparam logic [ADDR_W-1:0] A_LNMSK = 3'd6;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd7;

   // event bit positions in the event and mask words
   localparam int B_HOLD  = 0;
   localparam int B_WAKE  = 1;
   localparam int B_REL   = 2;
   localparam int B_DISC  = 4;
   localparam int B_BADK  = 5;
   localparam int B_NSUSP = 6;
   localparam int B_TMO   = 8;
   localparam int EVW_W   = 9;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_PRE   = 3'd2,
      ST_DRIVE = 3'd3,
      ST_DONE  = 3'd4,
      ST_FAIL  = 3'd5
   } wa_state_e;

   typedef struct packed {
      logic tmo;
      logic nsusp;
      logic badk;
      logic disc;
      logic rel;
      logic wake;
      logic hold;
   } wa_flags_t;

   typedef struct packed {
      logic mon_sel;
      logic link_ok;
      logic sys_ok;
   } wa_ctrl_t;

   function automatic logic [EVW_W-1:0] flags_word(input wa_flags_t f);
      logic [EVW_W-1:0] w;
      w          = '0;
      w[B_HOLD]  = f.hold;
      w[B_WAKE]  = f.wake;
      w[B_REL]   = f.rel;
      w[B_DISC]  = f.disc;
      w[B_BADK]  = f.badk;
      w[B_NSUSP] = f.nsusp;
      w[B_TMO]   = f.tmo;
      return w;
   endfunction

endpackage

// File: rtl/wa_line_decode.sv
module wa_line_decode
   import wa_pkg::*;
#(
   parameter logic [1:0] K_CODE = 2'b10
) (
   input  logic       mon_sel,
   input  logic [1:0] line_state,
   input  logic       fs_vp,
   input  logic       fs_vm,
   output logic       k_seen
);

   logic k_ls;
   logic k_cmp;

   assign k_ls   = (line_state == K_CODE);
   assign k_cmp  = ~fs_vp & fs_vm;
   assign k_seen = mon_sel ? k_ls : k_cmp;

endmodule

// File: rtl/wa_tick_counter.sv
module wa_tick_counter #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] nxt
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (&cnt) ? cnt : cnt + ONE;
      end else begin : g_wrap
         assign nxt = cnt + ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= nxt;
      end
   end

endmodule

// File: rtl/wa_seq.sv
module wa_seq
   import wa_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             suspended,
   input  logic             disc,
   input  logic             k_seen,
   input  logic             sys_ok,
   input  logic             link_ok,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] thr_delay,
   input  logic [CNT_W-1:0] thr_tmo,
   output wa_state_e        state,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output wa_flags_t        evt
);

   wa_state_e st_nxt;

   always_comb begin
      st_nxt  = state;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      evt     = '0;
      unique case (state)
         ST_IDLE: begin
            if (en) begin
               if (suspended) begin
                  st_nxt   = ST_WAIT;
                  evt.hold = 1'b1;
               end else begin
                  st_nxt    = ST_FAIL;
                  evt.nsusp = 1'b1;
               end
            end
         end
         ST_WAIT: begin
            if (!en) begin
               st_nxt = ST_IDLE;
            end else if (disc) begin
               st_nxt   = ST_FAIL;
               evt.disc = 1'b1;
            end else if (k_seen) begin
               st_nxt   = ST_PRE;
               cnt_clr  = 1'b1;
               evt.wake = 1'b1;
            end
         end
         ST_PRE: begin
            if (!en) begin
               st_nxt = ST_IDLE;
            end else if (disc) begin
               st_nxt   = ST_FAIL;
               evt.disc = 1'b1;
            end else if (!k_seen) begin
               st_nxt   = ST_FAIL;
               evt.badk = 1'b1;
            end else begin
               cnt_inc = 1'b1;
               if (cnt_nxt == thr_delay) begin
                  st_nxt = ST_DRIVE;
               end
            end
         end
         ST_DRIVE: begin
            if (!en) begin
               st_nxt = ST_IDLE;
            end else if (disc) begin
               st_nxt   = ST_FAIL;
               evt.disc = 1'b1;
            end else if (sys_ok && link_ok) begin
               st_nxt  = ST_DONE;
               evt.rel = 1'b1;
            end else begin
               cnt_inc = 1'b1;
               if (cnt_nxt == thr_tmo) begin
                  evt.tmo = 1'b1;
               end
            end
         end
         ST_DONE, ST_FAIL: begin
            if (!en) begin
               st_nxt = ST_IDLE;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         state <= st_nxt;
      end
   end

endmodule

// File: rtl/wake_assist_top.sv
module wake_assist_top
   import wa_pkg::*;
#(
   parameter int         DATA_W    = 32,
   parameter int         CNT_W     = 32,
   parameter bit         SATURATE  = 1'b1,
   parameter int         NOM_DELAY = 28,
   parameter int         NOM_TMO   = 656,
   parameter int         DET_LAT   = 3,
   parameter logic [1:0] K_CODE    = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              assist_en,
   input  logic              port_suspended,
   input  logic              port_disconnect,
   input  logic [1:0]        line_state,
   input  logic              fs_vp,
   input  logic              fs_vm,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              hostk_drive,
   output logic              done,
   output logic              error,
   output logic              irq_wake,
   output logic              irq_exc,
   output logic              irq_tmo,
   output logic              wake_req
);

   localparam int               DEF_DELAY = NOM_DELAY - DET_LAT;
   localparam int               DEF_TMO   = NOM_TMO - DET_LAT;
   localparam logic [CNT_W-1:0] DEF_DLY_V = CNT_W'(DEF_DELAY);
   localparam logic [CNT_W-1:0] DEF_TMO_V = CNT_W'(DEF_TMO);

   initial begin
      assert (CNT_W <= DATA_W) else $fatal(1, "counter wider than data word");
      assert (DATA_W >= EVW_W) else $fatal(1, "data word too narrow for event map");
      assert (DEF_DELAY >= 1 && DEF_TMO >= 1) else $fatal(1, "defaults must be positive");
      assert (CNT_W >= $clog2(NOM_TMO + 1)) else $fatal(1, "counter too narrow for default");
   end

   wa_ctrl_t          ctrl_q;
   logic [CNT_W-1:0]  dly_q;
   logic [CNT_W-1:0]  tmo_q;
   wa_flags_t         ev_q;
   wa_flags_t         ev_d;
   logic [5:0]        evm_q;
   logic [3:0]        lm_q;

   logic [CNT_W-1:0]  thr_delay;
   logic [CNT_W-1:0]  thr_tmo;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              cnt_clr;
   logic              cnt_inc;
   logic              k_seen;
   wa_state_e         state;
   wa_flags_t         evt;
   logic [DATA_W-1:0] w1c;
   logic              pend_wake;
   logic              pend_exc;

   // zero threshold falls back to the latency-corrected default
   assign thr_delay = (dly_q == '0) ? DEF_DLY_V : dly_q;
   assign thr_tmo   = (tmo_q == '0) ? DEF_TMO_V : tmo_q;

   wa_line_decode #(
      .K_CODE     (K_CODE)
   ) u_dec (
      .mon_sel    (ctrl_q.mon_sel),
      .line_state (line_state),
      .fs_vp      (fs_vp),
      .fs_vm      (fs_vm),
      .k_seen     (k_seen)
   );

   wa_tick_counter #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (cnt_q),
      .nxt   (cnt_nxt)
   );

   wa_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (assist_en),
      .suspended (port_suspended),
      .disc      (port_disconnect),
      .k_seen    (k_seen),
      .sys_ok    (ctrl_q.sys_ok),
      .link_ok   (ctrl_q.link_ok),
      .cnt_nxt   (cnt_nxt),
      .thr_delay (thr_delay),
      .thr_tmo   (thr_tmo),
      .state     (state),
      .cnt_clr   (cnt_clr),
      .cnt_inc   (cnt_inc),
      .evt       (evt)
   );

   // sticky event flags: a set in the same tick beats a write-one clear
   assign w1c = (wr_en && (wr_addr == A_EVT)) ? wr_data : '0;

   always_comb begin
      ev_d.hold  = evt.hold  | (ev_q.hold  & ~w1c[B_HOLD]);
      ev_d.wake  = evt.wake  | (ev_q.wake  & ~w1c[B_WAKE]);
      ev_d.rel   = evt.rel   | (ev_q.rel   & ~w1c[B_REL]);
      ev_d.disc  = evt.disc  | (ev_q.disc  & ~w1c[B_DISC]);
      ev_d.badk  = evt.badk  | (ev_q.badk  & ~w1c[B_BADK]);
      ev_d.nsusp = evt.nsusp | (ev_q.nsusp & ~w1c[B_NSUSP]);
      ev_d.tmo   = evt.tmo   | (ev_q.tmo   & ~w1c[B_TMO]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dly_q  <= '0;
         tmo_q  <= '0;
         ev_q   <= '0;
         evm_q  <= '0;
         lm_q   <= '0;
      end else begin
         ev_q <= ev_d;
         if (wr_en) begin
            unique case (wr_addr)
               A_CTRL:  ctrl_q <= wr_data[2:0];
               A_DELAY: dly_q  <= wr_data[CNT_W-1:0];
               A_TMO:   tmo_q  <= wr_data[CNT_W-1:0];
               A_EVMSK: evm_q  <= {wr_data[B_NSUSP], wr_data[B_BADK], wr_data[B_DISC],
                                   wr_data[B_REL], wr_data[B_WAKE], wr_data[B_HOLD]};
               A_LNMSK: lm_q   <= wr_data[3:0];
               default: ;
            endcase
         end
      end
   end

   // interrupt lines: per-flag mask, then per-line mask
   assign pend_wake = (ev_q.hold  & ~evm_q[0]) | (ev_q.wake & ~evm_q[1]) |
                      (ev_q.rel   & ~evm_q[2]);
   assign pend_exc  = (ev_q.disc  & ~evm_q[3]) | (ev_q.badk & ~evm_q[4]) |
                      (ev_q.nsusp & ~evm_q[5]);

   assign irq_wake    = pend_wake & ~lm_q[0];
   assign irq_exc     = pend_exc  & ~lm_q[1];
   assign irq_tmo     = ev_q.tmo  & ~lm_q[2];
   assign wake_req    = (irq_wake | irq_exc) & ~lm_q[3];

   assign hostk_drive = (state == ST_DRIVE);
   assign done        = (state == ST_DONE);
   assign error       = (state == ST_FAIL);

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL:  rd_data = DATA_W'(ctrl_q);
         A_DELAY: rd_data = DATA_W'(dly_q);
         A_TMO:   rd_data = DATA_W'(tmo_q);
         A_CNT:   rd_data = DATA_W'(cnt_q);
         A_EVT:   rd_data = DATA_W'(flags_word(ev_q));
         A_EVMSK: begin
            rd_data[B_HOLD]  = evm_q[0];
            rd_data[B_WAKE]  = evm_q[1];
            rd_data[B_REL]   = evm_q[2];
            rd_data[B_DISC]  = evm_q[3];
            rd_data[B_BADK]  = evm_q[4];
            rd_data[B_NSUSP] = evm_q[5];
         end
         A_LNMSK: rd_data = DATA_W'(lm_q);
         A_STAT:  rd_data = DATA_W'({hostk_drive, error, done});
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/wa_checker.sv
module wa_checker
   import wa_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hostk_drive,
   input logic             done,
   input logic             error,
   input logic [CNT_W-1:0] cnt_q,
   input logic             cnt_inc,
   input logic             cnt_clr,
   input logic [CNT_W-1:0] thr_delay,
   input wa_flags_t        ev
);

   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (cnt_q == '0));

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   assert_count_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_inc && !cnt_clr) |=> $stable(cnt_q));

   assert_hostk_at_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hostk_drive) |-> (cnt_q == $past(thr_delay)));

   assert_tmo_while_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev.tmo) |-> hostk_drive);

   assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ev.rel);

   assert_error_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> (ev.disc || ev.badk || ev.nsusp));

endmodule

bind wake_assist_top wa_checker #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hostk_drive (hostk_drive),
   .done        (done),
   .error       (error),
   .cnt_q       (cnt_q),
   .cnt_inc     (cnt_inc),
   .cnt_clr     (cnt_clr),
   .thr_delay   (thr_delay),
   .ev          (ev_q)
);

// File: tb/tb_wake_assist_top.sv
module tb_wake_assist_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        assist_en = 1'b0;
   logic        port_suspended = 1'b1;
   logic        port_disconnect = 1'b0;
   logic [1:0]  line_state = 2'b01;
   logic        fs_vp = 1'b1;
   logic        fs_vm = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = 3'd3;
   logic [31:0] rd_data;
   logic        hostk_drive, done, error, irq_wake, irq_exc, irq_tmo, wake_req;

   wake_assist_top dut (
      .clk(clk), .rst_n(rst_n), .assist_en(assist_en), .port_suspended(port_suspended),
      .port_disconnect(port_disconnect), .line_state(line_state), .fs_vp(fs_vp),
      .fs_vm(fs_vm), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .hostk_drive(hostk_drive), .done(done),
      .error(error), .irq_wake(irq_wake), .irq_exc(irq_exc), .irq_tmo(irq_tmo),
      .wake_req(wake_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   // behavioural reference model: 0 idle 1 wait 2 pre 3 drive 4 done 5 fail
   int          m_st;
   int unsigned m_cnt;
   bit [8:0]    m_ev;
   bit [2:0]    m_ctrl;
   int unsigned m_dly, m_tmo;
   bit [8:0]    m_evm;
   bit [3:0]    m_lm;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_ev = '0; m_ctrl = '0;
         m_dly = 0; m_tmo = 0; m_evm = '0; m_lm = '0;
      end else begin
         bit [8:0]    setv;
         bit          k;
         int unsigned dly, tmo, n;
         setv = '0;
         k   = m_ctrl[2] ? (line_state == 2'b10) : (!fs_vp && fs_vm);
         dly = (m_dly == 0) ? 25 : m_dly;
         tmo = (m_tmo == 0) ? 653 : m_tmo;
         case (m_st)
            0: if (assist_en) begin
                  if (port_suspended) begin m_st = 1; setv[0] = 1; end
                  else begin m_st = 5; setv[6] = 1; end
               end
            1: if (!assist_en) m_st = 0;
               else if (port_disconnect) begin m_st = 5; setv[4] = 1; end
               else if (k) begin m_st = 2; m_cnt = 0; setv[1] = 1; end
            2: if (!assist_en) m_st = 0;
               else if (port_disconnect) begin m_st = 5; setv[4] = 1; end
               else if (!k) begin m_st = 5; setv[5] = 1; end
               else begin
                  m_cnt = (m_cnt == 32'hFFFF_FFFF) ? m_cnt : m_cnt + 1;
                  if (m_cnt == dly) m_st = 3;
               end
            3: if (!assist_en) m_st = 0;
               else if (port_disconnect) begin m_st = 5; setv[4] = 1; end
               else if (m_ctrl[0] && m_ctrl[1]) begin m_st = 4; setv[2] = 1; end
               else begin
                  n = (m_cnt == 32'hFFFF_FFFF) ? m_cnt : m_cnt + 1;
                  if (n == tmo) setv[8] = 1;
                  m_cnt = n;
               end
            default: if (!assist_en) m_st = 0;
         endcase
         if (wr_en && wr_addr == 3'd4) m_ev = m_ev & ~wr_data[8:0];
         m_ev = m_ev | setv;
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_ctrl = wr_data[2:0];
               3'd1: m_dly  = wr_data;
               3'd2: m_tmo  = wr_data;
               3'd5: m_evm  = wr_data[8:0] & 9'h077;
               3'd6: m_lm   = wr_data[3:0];
               default: ;
            endcase
         end
      end
   end

   function automatic bit m_iwake();
      return (|(m_ev[2:0] & ~m_evm[2:0])) && !m_lm[0];
   endfunction
   function automatic bit m_iexc();
      return (|(m_ev[6:4] & ~m_evm[6:4])) && !m_lm[1];
   endfunction

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {29'd0, m_ctrl};
         3'd1: return m_dly;
         3'd2: return m_tmo;
         3'd3: return m_cnt;
         3'd4: return {23'd0, m_ev};
         3'd5: return {23'd0, m_evm};
         3'd6: return {28'd0, m_lm};
         default: return {29'd0, m_st == 3, m_st == 5, m_st == 4};
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one tick: wait for the falling edge, compare every output with the model
   task automatic cyc();
      @(negedge clk);
      chk("R5",  "hostk_drive", 32'(hostk_drive), 32'(m_st == 3));
      chk("R9",  "done",        32'(done),        32'(m_st == 4));
      chk("R8",  "error",       32'(error),       32'(m_st == 5));
      chk("R11", "irq_wake",    32'(irq_wake),    32'(m_iwake()));
      chk("R11", "irq_exc",     32'(irq_exc),     32'(m_iexc()));
      chk("R11", "irq_tmo",     32'(irq_tmo),     32'(m_ev[8] && !m_lm[2]));
      chk("R11", "wake_req",    32'(wake_req),    32'((m_iwake() || m_iexc()) && !m_lm[3]));
      chk("R13", "rd_data",     rd_data,          m_read(rd_addr));
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(req, "register read", rd_data, exp);
      rd_addr = 3'd3;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) cyc();
      // R1: reset state
      for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 32'd0);
      chk("R1", "irq lines", 32'({irq_wake, irq_exc, irq_tmo, wake_req, done, error}), 32'd0);
      rst_n = 1'b1;
      cyc();

      // scenario A: defaults, line-state decode
      wr(3'd0, 32'h4);
      assist_en = 1'b1;
      cyc();
      rd_chk("R2", 3'd4, 32'h001);
      fs_vp = 1'b0; fs_vm = 1'b1;            // comparator K, not selected
      repeat (3) cyc();
      rd_chk("R3", 3'd4, 32'h001);
      rd_chk("R3", 3'd7, 32'h0);
      fs_vp = 1'b1; fs_vm = 1'b0;
      line_state = 2'b10;                    // selected K
      cyc();
      rd_chk("R4", 3'd3, 32'd0);
      rd_chk("R4", 3'd4, 32'h003);
      repeat (24) cyc();
      rd_chk("R4", 3'd3, 32'd24);
      chk("R5", "hostk before default delay", 32'(hostk_drive), 32'd0);
      cyc();
      chk("R5", "hostk at default delay 25", 32'(hostk_drive), 32'd1);
      repeat (627) cyc();
      chk("R6", "timeout before 653", 32'(irq_tmo), 32'd0);
      cyc();
      chk("R6", "timeout at default 653", 32'(irq_tmo), 32'd1);
      rd_chk("R6", 3'd4, 32'h103);
      wr(3'd0, 32'h7);
      cyc();
      chk("R9", "done after handshake", 32'(done), 32'd1);
      rd_chk("R9", 3'd3, 32'd654);
      repeat (3) cyc();
      rd_chk("R9", 3'd3, 32'd654);
      rd_chk("R9", 3'd4, 32'h107);
      wr(3'd4, 32'h1FF);
      rd_chk("R10", 3'd4, 32'h0);
      chk("R11", "lines after clear", 32'({irq_wake, irq_exc, irq_tmo, wake_req}), 32'd0);
      assist_en = 1'b0;
      line_state = 2'b01;
      cyc();
      chk("R12", "done dropped", 32'(done), 32'd0);

      // scenario B: comparator decode, short K, masks
      wr(3'd0, 32'h0);
      wr(3'd1, 32'd4);
      assist_en = 1'b1;
      cyc();
      line_state = 2'b10;                    // line-state K, not selected
      cyc();
      rd_chk("R3", 3'd4, 32'h001);
      line_state = 2'b01;
      fs_vp = 1'b0; fs_vm = 1'b1;
      cyc();
      cyc();
      rd_chk("R4", 3'd3, 32'd1);
      fs_vp = 1'b1; fs_vm = 1'b0;
      cyc();
      chk("R7", "error on short K", 32'(error), 32'd1);
      rd_chk("R7", 3'd4, 32'h023);
      chk("R11", "exception line", 32'(irq_exc), 32'd1);
      chk("R11", "wake request", 32'(wake_req), 32'd1);
      wr(3'd5, 32'h23);
      chk("R11", "masked lines", 32'({irq_wake, irq_exc, wake_req}), 32'd0);
      wr(3'd5, 32'h0);
      wr(3'd6, 32'h8);
      chk("R11", "request masked", 32'({irq_wake, irq_exc, wake_req}), 32'b110);
      wr(3'd6, 32'h0);
      assist_en = 1'b0;
      cyc();
      chk("R12", "error dropped", 32'(error), 32'd0);
      rd_chk("R12", 3'd3, 32'd1);
      wr(3'd4, 32'h1FF);

      // set beats clear; not suspended at enable
      port_suspended = 1'b0;
      assist_en = 1'b1;
      wr(3'd4, 32'h40);
      rd_chk("R10", 3'd4, 32'h040);
      chk("R2", "error when not suspended", 32'(error), 32'd1);
      assist_en = 1'b0;
      port_suspended = 1'b1;
      cyc();
      wr(3'd4, 32'h1FF);

      // scenario C: disconnect while monitoring
      assist_en = 1'b1;
      cyc();
      port_disconnect = 1'b1;
      cyc();
      chk("R8", "error on disconnect", 32'(error), 32'd1);
      rd_chk("R8", 3'd4, 32'h011);
      port_disconnect = 1'b0;
      assist_en = 1'b0;
      cyc();
      wr(3'd4, 32'h1FF);

      // scenario D: programmed thresholds, disable while driving
      wr(3'd1, 32'd3);
      wr(3'd2, 32'd6);
      wr(3'd0, 32'h4);
      assist_en = 1'b1;
      cyc();
      line_state = 2'b10;
      cyc();
      repeat (2) cyc();
      chk("R5", "hostk before programmed delay", 32'(hostk_drive), 32'd0);
      cyc();
      chk("R5", "hostk at programmed delay", 32'(hostk_drive), 32'd1);
      rd_chk("R13", 3'd7, 32'h4);
      repeat (2) cyc();
      chk("R6", "timeout before 6", 32'(irq_tmo), 32'd0);
      cyc();
      chk("R6", "timeout at 6", 32'(irq_tmo), 32'd1);
      assist_en = 1'b0;
      cyc();
      chk("R12", "hostk dropped", 32'(hostk_drive), 32'd0);
      repeat (2) cyc();
      rd_chk("R12", 3'd3, 32'd6);
      line_state = 2'b01;
      cyc();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule